// File: doc/BRIEF.md
# Trigger-Gated Pad Hit Recorder

The recorder watches 64 discriminated hit lines from an 8x8 array of 1x1 cm² detector pads. When an external trigger rises, it collects the hit lines over a short coincidence window. It then forms a 74-bit event: the 64 hit bits in the low part and a 10-bit running trigger number above them. The event goes into an on-chip FIFO, where it waits for the rest of the beam spill.

An end-of-spill strobe starts a drain. The stored events leave one by one as ten bytes each, least significant byte first, on an 8N1 asynchronous serial line to a host computer. New triggers are refused while a drain is under way. Triggers that arrive while the FIFO is full are dropped and raise a sticky overflow flag, which the end of the next drain clears.

All asynchronous inputs (hits, trigger, end-of-spill) pass through synchronisers before use.

Top module: `pad_event_recorder`

## Requirements
- R1: After reset, tx_o is high (line idle), drain_o is low and ovf_o is low.
- R2: Let T be the first clock edge that samples trig_i high. A hit line sampled high at any of the edges T+1 to T+L sets its bit in the recorded event. L is the effective window length.
- R3: A hit line sampled high only outside the edges T+1 to T+L (including edge T itself) leaves its bit clear.
- R4: Event numbers start at 0 after reset. They advance by one for each accepted trigger only and wrap from 1023 to 0.
- R5: Each event goes out as exactly 10 bytes. Bytes 0 to 7 carry hit bits 0 to 63, with the least significant byte first. Byte 8 holds event number bits 7:0. Byte 9 holds event number bits 9:8 in its bits 1:0, and its bits 7:2 are zero.
- R6: Each byte is framed as one low start bit, eight data bits LSB first and one high stop bit. Each bit lasts CLKS_PER_BIT clocks, and the line rests high between frames.
- R7: Stored events are kept, with nothing sent, until an end-of-spill rising edge. They then leave in the order they were accepted.
- R8: A trigger that arrives while the FIFO holds FIFO_DEPTH events stores nothing and does not advance the event number. It sets ovf_o, which stays high until the end of the next drain.
- R9: When a drain finishes, drain_o falls and ovf_o is low.
- R10: A trigger that arrives while drain_o is high produces no event and does not advance the event number.
- R11: The window length L equals win_len_i (1 to 15). A value of 0 is treated as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hit_i | input | 64 | Discriminated pad hit lines, asynchronous |
| trig_i | input | 1 | External trigger, asynchronous, rising edge active |
| eos_i | input | 1 | End-of-spill strobe, asynchronous, rising edge active |
| win_len_i | input | 4 | Coincidence window length in clocks |
| tx_o | output | 1 | Serial data to the host, idle high |
| drain_o | output | 1 | A drain is pending or in progress |
| ovf_o | output | 1 | Sticky FIFO overflow flag |

## Verification
The assertions check several rules on every cycle:
- the event number moves only when an event is pushed, and then by exactly one;
- a trigger seen during a drain never opens a window;
- the FIFO is never pushed when full or popped when empty;
- the overflow flag stays set until a drain completes and is low just after one;
- every byte handed to the serial transmitter starts with a low start bit.

Only the bench's scenarios can show the rest. These are the placement of the window edges relative to the trigger, the exact byte order and contents of each event, the in-order release of stored events after the strobe, the dropped events past the FIFO limit, and the wrap of the event number past 1023.

// File: rtl/pad_rec_pkg.sv
package pad_rec_pkg;
  typedef enum logic [1:0] {
    D_IDLE,
    D_LOAD,
    D_SEND
  } drain_state_e;
endpackage

// File: rtl/sync_bus.sv
module sync_bus #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stg
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg[g] <= '0;
        else         stg[g] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg[g] <= '0;
        else         stg[g] <= stg[g-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/event_fifo.sv
module event_fifo #(
  parameter int W     = 74,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] wdata_i,
  input  logic         pop_i,
  output logic [W-1:0] rdata_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic [CW-1:0] count;

  assign full_o  = (count == CW'(DEPTH));
  assign empty_o = (count == '0);
  assign rdata_o = mem[rptr];

  always_ff @(posedge clk_i)
    if (push_i) mem[wptr] <= wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push_i) wptr <= (wptr == PW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (pop_i)  rptr <= (rptr == PW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      if (push_i && !pop_i)      count <= count + 1'b1;
      else if (pop_i && !push_i) count <= count - 1'b1;
    end
  end

  a_r8_no_push_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  a_r7_no_pop_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/uart_tx.sv
module uart_tx #(
  parameter int CLKS_PER_BIT = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       valid_i,
  input  logic [7:0] data_i,
  output logic       ready_o,
  output logic       tx_o
);
  localparam int CW = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;

  logic [9:0]    sh;
  logic [3:0]    bits_left;
  logic [CW-1:0] tick;
  logic          busy;

  assign busy    = (bits_left != '0);
  assign ready_o = !busy;
  assign tx_o    = busy ? sh[0] : 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh        <= '1;
      bits_left <= '0;
      tick      <= '0;
    end else if (!busy) begin
      if (valid_i) begin
        sh        <= {1'b1, data_i, 1'b0};
        bits_left <= 4'd10;
        tick      <= CW'(CLKS_PER_BIT - 1);
      end
    end else if (tick == '0) begin
      sh        <= {1'b1, sh[9:1]};
      bits_left <= bits_left - 1'b1;
      tick      <= CW'(CLKS_PER_BIT - 1);
    end else begin
      tick <= tick - 1'b1;
    end
  end

  a_r6_start_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_o) |=> !tx_o);
endmodule

// File: rtl/pad_event_recorder.sv
module pad_event_recorder
  import pad_rec_pkg::*;
#(
  parameter int N_HITS       = 64,
  parameter int NUM_W        = 10,
  parameter int FIFO_DEPTH   = 4,
  parameter int CLKS_PER_BIT = 16,
  parameter int SYNC_STAGES  = 2,
  parameter int WIN_W        = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_HITS-1:0] hit_i,
  input  logic              trig_i,
  input  logic              eos_i,
  input  logic [WIN_W-1:0]  win_len_i,
  output logic              tx_o,
  output logic              drain_o,
  output logic              ovf_o
);
  localparam int REC_W   = N_HITS + NUM_W;
  localparam int N_BYTES = (REC_W + 7) / 8;
  localparam int PAD_W   = N_BYTES * 8;
  localparam int BI_W    = $clog2(N_BYTES);

  logic [N_HITS-1:0] hit_s;
  logic [1:0]        ctl_s;
  logic              trig_d, eos_d, trig_edge, eos_edge;

  sync_bus #(.W(N_HITS), .STAGES(SYNC_STAGES)) u_sync_hit (
    .clk_i, .rst_ni, .d_i(hit_i), .q_o(hit_s));
  sync_bus #(.W(2), .STAGES(SYNC_STAGES)) u_sync_ctl (
    .clk_i, .rst_ni, .d_i({eos_i, trig_i}), .q_o(ctl_s));

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) {eos_d, trig_d} <= '0;
    else         {eos_d, trig_d} <= ctl_s;

  assign trig_edge = ctl_s[0] && !trig_d;
  assign eos_edge  = ctl_s[1] && !eos_d;

  // capture window
  logic              win_open, push, busy, drain_done;
  logic [WIN_W-1:0]  win_cnt;
  logic [N_HITS-1:0] acc;
  logic [NUM_W-1:0]  trig_num;
  logic              ovf_q;
  logic              fifo_full, fifo_empty, pop;
  logic [REC_W-1:0]  fifo_rdata;

  assign push = win_open && (win_cnt == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_open <= 1'b0;
      win_cnt  <= '0;
      acc      <= '0;
      trig_num <= '0;
      ovf_q    <= 1'b0;
    end else begin
      if (win_open) begin
        acc <= acc | hit_s;
        if (win_cnt == '0) win_open <= 1'b0;
        else               win_cnt  <= win_cnt - 1'b1;
      end else if (trig_edge && !busy) begin
        if (fifo_full) begin
          ovf_q <= 1'b1;
        end else begin
          win_open <= 1'b1;
          win_cnt  <= (win_len_i == '0) ? '0 : win_len_i - 1'b1;
          acc      <= '0;
        end
      end
      if (push) trig_num <= trig_num + 1'b1;
      if (drain_done) ovf_q <= 1'b0;
    end
  end

  event_fifo #(.W(REC_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i, .rst_ni,
    .push_i  (push),
    .wdata_i ({trig_num, acc | hit_s}),
    .pop_i   (pop),
    .rdata_o (fifo_rdata),
    .full_o  (fifo_full),
    .empty_o (fifo_empty));

  // drain sequencer
  drain_state_e      d_state;
  logic              drain_pend;
  logic [PAD_W-1:0]  sh;
  logic [BI_W-1:0]   byte_idx;
  logic              tx_valid, tx_ready, last_byte;

  assign busy      = drain_pend || (d_state != D_IDLE);
  assign pop       = (d_state == D_LOAD);
  assign tx_valid  = (d_state == D_SEND);
  assign last_byte = (byte_idx == BI_W'(N_BYTES - 1));
  assign drain_done =
      ((d_state == D_IDLE) && drain_pend && !win_open && fifo_empty) ||
      ((d_state == D_SEND) && tx_ready && last_byte && fifo_empty);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      d_state    <= D_IDLE;
      drain_pend <= 1'b0;
      sh         <= '0;
      byte_idx   <= '0;
    end else begin
      unique case (d_state)
        D_IDLE: begin
          if (drain_pend && !win_open) begin
            drain_pend <= 1'b0;
            if (!fifo_empty) d_state <= D_LOAD;
          end else if (eos_edge) begin
            drain_pend <= 1'b1;
          end
        end
        D_LOAD: begin
          sh       <= PAD_W'(fifo_rdata);
          byte_idx <= '0;
          d_state  <= D_SEND;
        end
        D_SEND: begin
          if (tx_ready) begin
            sh <= sh >> 8;
            if (last_byte) d_state  <= fifo_empty ? D_IDLE : D_LOAD;
            else           byte_idx <= byte_idx + 1'b1;
          end
        end
        default: d_state <= D_IDLE;
      endcase
    end
  end

  uart_tx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_uart (
    .clk_i, .rst_ni,
    .valid_i (tx_valid),
    .data_i  (sh[7:0]),
    .ready_o (tx_ready),
    .tx_o    (tx_o));

  assign drain_o = busy;
  assign ovf_o   = ovf_q;

  a_r4_num_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push |=> trig_num == $past(trig_num) + 1'b1);
  a_r4_num_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !push |=> $stable(trig_num));
  a_r10_no_capture_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_edge && busy && !win_open) |=> !win_open);
  a_r8_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !drain_done) |=> ovf_q);
  a_r9_ovf_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drain_done |=> !ovf_q);
endmodule

// File: tb/pad_event_recorder_tb.sv
module pad_event_recorder_tb;
  localparam int DEPTH = 16;
  localparam int CPB   = 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] hit = '0;
  logic        trig = 1'b0, eos = 1'b0;
  logic [3:0]  win_len = 4'd4;
  logic        tx, drain, ovf;

  int n_chk = 0, n_fail = 0;
  logic [7:0] exp_q[$];
  int  m_num = 0, m_cnt = 0;
  bit  m_ovf = 1'b0;
  bit  rx_busy = 1'b0;
  bit  done = 1'b0;

  always #10 clk = ~clk;

  pad_event_recorder #(.FIFO_DEPTH(DEPTH), .CLKS_PER_BIT(CPB)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .hit_i(hit), .trig_i(trig), .eos_i(eos),
    .win_len_i(win_len), .tx_o(tx), .drain_o(drain), .ovf_o(ovf));

  task automatic chk(bit ok, string tag, logic [79:0] act, logic [79:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // serial decoder: compares every byte with the reference queue
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && tx === 1'b0) begin
        logic [7:0] b;
        rx_busy = 1'b1;
        for (int i = 0; i < 8; i++) begin
          repeat (CPB) @(negedge clk);
          b[i] = tx;
        end
        repeat (CPB) @(negedge clk);
        chk(tx === 1'b1, "R6 stop bit", 80'(tx), 80'(1));
        if (exp_q.size() == 0) chk(1'b0, "R7 unexpected byte", 80'(b), 80'(0));
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(b == e, "R5 byte", 80'(b), 80'(e));
        end
        rx_busy = 1'b0;
      end
    end
  end

  // per-clock: line idles whenever the model expects no bytes
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && !rx_busy && exp_q.size() == 0)
        chk(tx === 1'b1, "R7 idle line", 80'(tx), 80'(1));
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 0);
    finish_run();
  end

  task automatic fire(logic [63:0] h, int lo, int hi, bit model);
    if (model) begin
      if (m_cnt == DEPTH) m_ovf = 1'b1;
      else begin
        int weff;
        logic [63:0] hv;
        logic [79:0] rec;
        weff = (win_len == 0) ? 1 : int'(win_len);
        hv   = (lo <= weff && hi >= 1) ? h : '0;
        rec  = {6'd0, 10'(m_num), hv};
        for (int i = 0; i < 10; i++) exp_q.push_back(rec[8*i +: 8]);
        m_cnt++;
        m_num = (m_num + 1) % 1024;
      end
    end
    @(negedge clk);
    trig = 1'b1;
    hit  = (lo <= 0 && hi >= 0) ? h : '0;
    for (int k = 1; k <= 20; k++) begin
      @(negedge clk);
      hit = (k >= lo && k <= hi) ? h : '0;
      if (k == 3) trig = 1'b0;
    end
    hit = '0;
  endtask

  task automatic wait_drain(bit pulse);
    int t;
    if (pulse) begin
      @(negedge clk); eos = 1'b1;
      repeat (3) @(negedge clk);
      eos = 1'b0;
    end
    t = 0;
    while ((exp_q.size() != 0 || rx_busy || drain) && t < 8000) begin
      @(negedge clk); t++;
    end
    repeat (3) @(negedge clk);
    chk(t < 8000 && exp_q.size() == 0, "R7 drain completes", 80'(exp_q.size()), 0);
    chk(drain == 1'b0, "R9 drain_o low", 80'(drain), 0);
    chk(ovf == 1'b0, "R9 ovf cleared", 80'(ovf), 0);
    m_cnt = 0;
    m_ovf = 1'b0;
  endtask

  function automatic logic [63:0] pat(int k);
    return {32'(k) * 32'h9E3779B1, ~(32'(k) * 32'h85EBCA6B)};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    chk(tx === 1'b1, "R1 tx idle", 80'(tx), 1);
    chk(drain === 1'b0, "R1 drain low", 80'(drain), 0);
    chk(ovf === 1'b0, "R1 ovf low", 80'(ovf), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R2 R3 R11 window placement
    win_len = 4'd4;
    fire(pat(1), 1, 1, 1);   // R2 first window edge
    fire(pat(2), 4, 4, 1);   // R11 last window edge
    fire(pat(3), 5, 8, 1);   // R3 after window
    fire(pat(4), 0, 0, 1);   // R3 trigger edge itself
    win_len = 4'd1;
    fire(pat(5), 2, 2, 1);   // R11 outside len 1
    fire(pat(6), 1, 1, 1);
    win_len = 4'd0;
    fire(pat(7), 1, 1, 1);   // R11 zero treated as one
    fire(pat(8), 2, 2, 1);
    win_len = 4'd15;
    fire(pat(9), 15, 15, 1); // R11 longest window
    repeat (50) @(negedge clk);
    chk(ovf == 1'b0, "R8 no overflow yet", 80'(ovf), 0);
    wait_drain(1'b1);

    // R8 overflow: two drops, numbering keeps no gap (R4)
    win_len = 4'd2;
    for (int k = 0; k < DEPTH + 2; k++) begin
      fire(pat(100 + k), 1, 2, 1);
      chk(ovf == m_ovf, "R8 ovf flag", 80'(ovf), 80'(m_ovf));
    end
    wait_drain(1'b1);

    // R10 triggers during drain ignored
    for (int k = 0; k < 3; k++) fire(pat(200 + k), 1, 1, 1);
    @(negedge clk); eos = 1'b1;
    repeat (3) @(negedge clk);
    eos = 1'b0;
    repeat (3) @(negedge clk);
    chk(drain == 1'b1, "R10 drain active", 80'(drain), 1);
    fire(pat(300), 1, 2, 0);
    fire(pat(301), 1, 2, 0);
    wait_drain(1'b0);
    fire(pat(302), 1, 1, 1);
    wait_drain(1'b1);

    // R4 wrap past 1023
    while (m_num < 1030 && m_num >= 20) begin
      for (int k = 0; k < DEPTH; k++) fire(pat(m_num), 1, 1, 1);
      wait_drain(1'b1);
    end
    for (int k = 0; k < 4; k++) fire(pat(k + 7), 1, 1, 1);
    wait_drain(1'b1);
    chk(m_num < 20, "R4 wrap reached", 80'(m_num), 0);
    finish_run();
  end
endmodule